// File: doc/BRIEF.md
# Low-Power Mode Controller

This block follows the power state of an LPDDR-style memory device from the clock-enable line and the decoded command sampled on each rising clock edge. It tells apart normal operation, power down, self refresh and deep power down. It recognises entry to each low-power state from a falling clock enable combined with a qualifying command. Exit happens when the clock enable returns high together with a no-operation command. After exit it enforces the required waiting periods.

Deep power down is handled in a special way. Everything the device held is treated as lost, including its mode settings. Leaving that state therefore starts a complete power-up re-initialization. First comes a wait period, then a fixed series of commands: a precharge of all banks, a configurable number of refreshes, the mode setting and the extended mode setting. Until that series completes, only no-operation commands are tolerated.

A memory controller places this block next to its command scheduler. The registered command-allowed flag tells the scheduler that the command sampled on the previous edge was legal in the power state of that time. The registered error flag marks a command that broke the power-state rules and was therefore not taken.

Top module: `lp_mode_ctrl`

## Requirements
- R1: After synchronous reset the mode output is 0 (normal), and both the allowed flag and the error flag are 0. The mode codes are: 0 normal, 1 power down, 2 self refresh, 3 deep power down, 4 self-refresh recovery, 5 re-initialization.
- R2: The command codes are: NOP=0, DESL=1, ACT=2, READ=3, WRITE=4, PRE=5, PALL=6, REF=7, MRS=8, EMRS=9, BST=10. In normal mode, an edge with clock enable high accepts any command. The allowed flag is then 1 and the error flag is 0.
- R3: In normal mode, a falling clock enable (high on the previous edge, low on this one) with NOP or DESL enters power down (mode 1) and is accepted.
- R4: In power down or self refresh, an edge with clock enable low ignores the command: the mode is unchanged and both flags are 0. Clock enable high with NOP or DESL leaves power down straight to normal, so an ACT on the following edge is accepted.
- R5: In normal mode, a falling clock enable with REF enters self refresh (mode 2), and with BST enters deep power down (mode 3), but only when all banks are idle. Any other low clock enable in normal mode raises the error flag, and the mode stays normal. This covers a low enable with no falling edge, a wrong command, or banks that are not idle.
- R6: An attempt to leave power down or self refresh with a command other than NOP or DESL raises the error flag and leaves the mode unchanged.
- R7: A valid self refresh exit enters recovery (mode 4) for REFC_CYC further edges, the last of which returns to normal. During recovery any command other than NOP/DESL, or a low clock enable, raises the error flag.
- R8: In deep power down, every input except clock enable is ignored and both flags stay 0. The first edge with clock enable high enters re-initialization (mode 5) whatever command is present.
- R9: Re-initialization first counts INIT_WAIT edges, which accept only NOP/DESL. It then requires PALL, INIT_REFS times REF, MRS and EMRS in that order, with NOP/DESL allowed in between. An early or out-of-order command raises the error flag and does not advance the series. Acceptance of EMRS returns the mode to normal on that edge.
- R10: The allowed flag and the error flag are never 1 together, and each reflects only the command of the latest edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable as driven to the memory |
| cmd | input | 4 | Decoded command code (R2 encoding) |
| banks_idle | input | 1 | All banks are precharged and data lines released |
| mode | output | 3 | Current power mode (R1 encoding) |
| cmd_ok | output | 1 | Command of the last edge was accepted |
| cmd_err | output | 1 | Command of the last edge broke the power-state rules |

## Verification
The assertions assume that the command input always holds one of the eleven defined codes. They also assume that banks_idle is a truthful summary from the scheduler, sampled on the same edge as the command. The stimulus keeps to this by driving only the named codes, and it changes cke, cmd and banks_idle together on the falling clock edge. Illegal sequences are still sent on purpose: a premature PALL during the initialization wait, an out-of-order EMRS, an ACT during recovery, and entries while the banks are busy. This exercises the error paths without ever driving an undefined code.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam logic [3:0] CMD_NOP   = 4'd0;
  localparam logic [3:0] CMD_DESL  = 4'd1;
  localparam logic [3:0] CMD_ACT   = 4'd2;
  localparam logic [3:0] CMD_READ  = 4'd3;
  localparam logic [3:0] CMD_WRITE = 4'd4;
  localparam logic [3:0] CMD_PRE   = 4'd5;
  localparam logic [3:0] CMD_PALL  = 4'd6;
  localparam logic [3:0] CMD_REF   = 4'd7;
  localparam logic [3:0] CMD_MRS   = 4'd8;
  localparam logic [3:0] CMD_EMRS  = 4'd9;
  localparam logic [3:0] CMD_BST   = 4'd10;

  typedef enum logic [2:0] {
    MD_NORM  = 3'd0,
    MD_PDN   = 3'd1,
    MD_SREF  = 3'd2,
    MD_DPD   = 3'd3,
    MD_RECOV = 3'd4,
    MD_INIT  = 3'd5
  } lpm_mode_e;

  function automatic logic is_quiet(input logic [3:0] c);
    return (c == CMD_NOP) || (c == CMD_DESL);
  endfunction
endpackage

// File: rtl/lpm_wait_cnt.sv
module lpm_wait_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                    cnt_q <= '0;
    else if (load)              cnt_q <= load_val;
    else if (dec && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R7
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero);
endmodule

// File: rtl/lpm_init_seq.sv
module lpm_init_seq #(
  parameter int INIT_REFS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       advance,
  output logic [3:0] exp_cmd,
  output logic       last
);
  import lpm_pkg::*;

  localparam int STEPS = INIT_REFS + 3;
  localparam int SW    = $clog2(STEPS);

  logic [SW-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst || clear)          step_q <= '0;
    else if (advance && !last) step_q <= step_q + 1'b1;
  end

  always_comb begin
    if (step_q == '0)                        exp_cmd = CMD_PALL;
    else if (step_q <= SW'(INIT_REFS))       exp_cmd = CMD_REF;
    else if (step_q == SW'(INIT_REFS + 1))   exp_cmd = CMD_MRS;
    else                                     exp_cmd = CMD_EMRS;
  end

  assign last = (step_q == SW'(STEPS - 1));

  // R9
  seq_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    step_q <= SW'(STEPS - 1));
endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl #(
  parameter int REFC_CYC  = 12,
  parameter int INIT_WAIT = 40000,
  parameter int INIT_REFS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cke,
  input  logic [3:0] cmd,
  input  logic       banks_idle,
  output logic [2:0] mode,
  output logic       cmd_ok,
  output logic       cmd_err
);
  import lpm_pkg::*;

  localparam int MAXW = (REFC_CYC > INIT_WAIT) ? REFC_CYC : INIT_WAIT;
  localparam int CW   = $clog2(MAXW + 1);

  lpm_mode_e mode_q, nxt_mode;
  logic      ok_q, err_q, cke_q;
  logic      nxt_ok, nxt_err;
  logic      cnt_load, cnt_dec, cnt_zero;
  logic [CW-1:0] cnt_val;
  logic      seq_clear, seq_adv, seq_last;
  logic [3:0] seq_cmd;
  logic      quiet, fall;

  assign quiet = is_quiet(cmd);
  assign fall  = cke_q && !cke;

  lpm_wait_cnt #(.W(CW)) wait_i (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .zero(cnt_zero)
  );

  lpm_init_seq #(.INIT_REFS(INIT_REFS)) seq_i (
    .clk(clk), .rst(rst), .clear(seq_clear), .advance(seq_adv),
    .exp_cmd(seq_cmd), .last(seq_last)
  );

  always_comb begin
    nxt_mode  = mode_q;
    nxt_ok    = 1'b0;
    nxt_err   = 1'b0;
    cnt_load  = 1'b0;
    cnt_val   = CW'(REFC_CYC - 1);
    cnt_dec   = 1'b0;
    seq_clear = 1'b0;
    seq_adv   = 1'b0;
    case (mode_q)
      MD_NORM: begin
        if (cke) nxt_ok = 1'b1;
        else if (fall && quiet) begin
          nxt_mode = MD_PDN; nxt_ok = 1'b1;
        end else if (fall && cmd == CMD_REF && banks_idle) begin
          nxt_mode = MD_SREF; nxt_ok = 1'b1;
        end else if (fall && cmd == CMD_BST && banks_idle) begin
          nxt_mode = MD_DPD; nxt_ok = 1'b1;
        end else nxt_err = 1'b1;
      end
      MD_PDN: begin
        if (cke) begin
          if (quiet) begin nxt_mode = MD_NORM; nxt_ok = 1'b1; end
          else nxt_err = 1'b1;
        end
      end
      MD_SREF: begin
        if (cke) begin
          if (quiet) begin
            nxt_mode = MD_RECOV; nxt_ok = 1'b1; cnt_load = 1'b1;
          end else nxt_err = 1'b1;
        end
      end
      MD_DPD: begin
        if (cke) begin
          nxt_mode  = MD_INIT;
          cnt_load  = 1'b1;
          cnt_val   = CW'(INIT_WAIT);
          seq_clear = 1'b1;
        end
      end
      MD_RECOV: begin
        cnt_dec = 1'b1;
        if (cke && quiet) begin
          nxt_ok = 1'b1;
          if (cnt_zero) nxt_mode = MD_NORM;
        end else nxt_err = 1'b1;
      end
      MD_INIT: begin
        if (!cke) nxt_err = 1'b1;
        else if (!cnt_zero) begin
          cnt_dec = 1'b1;
          if (quiet) nxt_ok = 1'b1; else nxt_err = 1'b1;
        end else if (quiet) nxt_ok = 1'b1;
        else if (cmd == seq_cmd) begin
          nxt_ok  = 1'b1;
          seq_adv = 1'b1;
          if (seq_last) nxt_mode = MD_NORM;
        end else nxt_err = 1'b1;
      end
      default: nxt_mode = MD_NORM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_NORM;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
      cke_q  <= 1'b1;
    end else begin
      mode_q <= nxt_mode;
      ok_q   <= nxt_ok;
      err_q  <= nxt_err;
      cke_q  <= cke;
    end
  end

  assign mode    = mode_q;
  assign cmd_ok  = ok_q;
  assign cmd_err = err_q;

  // R10
  ok_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ok_q && err_q));

  // R5
  dpd_needs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_NORM && cke_q && !cke && cmd == CMD_BST && !banks_idle)
      |=> (mode_q == MD_NORM && err_q));

  // R8
  dpd_inputs_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_DPD && !cke) |=> (mode_q == MD_DPD && !ok_q && !err_q));

  // R8
  dpd_exit_init_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_DPD && cke) |=> (mode_q == MD_INIT));

  // R9
  init_exit_norm_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_INIT) |=> (mode_q == MD_INIT || mode_q == MD_NORM));

  // R7
  recov_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_RECOV && cke && !quiet) |=> (err_q && mode_q == MD_RECOV));
endmodule

// File: tb/lp_mode_ctrl_tb_top.sv
module lp_mode_ctrl_tb_top;
  import lpm_pkg::*;

  typedef struct {
    logic [2:0] mode;
    logic       ok;
    logic       err;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1;
  logic [3:0] cmd = CMD_NOP;
  logic banks_idle = 1'b1;
  logic [2:0] mode;
  logic cmd_ok, cmd_err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  lp_mode_ctrl #(.REFC_CYC(4), .INIT_WAIT(3), .INIT_REFS(2)) dut_i (
    .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .banks_idle(banks_idle),
    .mode(mode), .cmd_ok(cmd_ok), .cmd_err(cmd_err)
  );

  task automatic drive(input logic c, input logic [3:0] k, input logic idle,
                       input logic [2:0] em, input logic eo, input logic ee,
                       input string tag);
    exp_t e;
    @(negedge clk);
    cke = c; cmd = k; banks_idle = idle;
    e.mode = em; e.ok = eo; e.err = ee; e.tag = tag;
    sb_q.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (!rst && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (mode !== e.mode || cmd_ok !== e.ok || cmd_err !== e.err) begin
        errors++;
        $display("FAIL %s: got mode=%0d ok=%0b err=%0b, expected mode=%0d ok=%0b err=%0b",
                 e.tag, mode, cmd_ok, cmd_err, e.mode, e.ok, e.err);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (mode !== 3'd0 || cmd_ok !== 1'b0 || cmd_err !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got mode=%0d ok=%0b err=%0b, expected mode=0 ok=0 err=0",
               mode, cmd_ok, cmd_err);
    end
    rst = 1'b0;
    // R2 normal operation
    drive(1, CMD_ACT,   1, 0, 1, 0, "R2 act");
    drive(1, CMD_WRITE, 0, 0, 1, 0, "R2 write");
    // R3 power down entry, R4 hold and exit
    drive(0, CMD_DESL,  1, 1, 1, 0, "R3 pd entry");
    drive(0, CMD_ACT,   1, 1, 0, 0, "R4 pd ignore");
    drive(1, CMD_READ,  1, 1, 0, 1, "R6 pd bad exit");
    drive(1, CMD_NOP,   1, 0, 1, 0, "R4 pd exit");
    drive(1, CMD_ACT,   1, 0, 1, 0, "R4 act after exit");
    // R5 refused entries
    drive(0, CMD_REF,   0, 0, 0, 1, "R5 sref busy");
    drive(0, CMD_NOP,   1, 0, 0, 1, "R5 low no fall");
    drive(1, CMD_NOP,   1, 0, 1, 0, "R2 back high");
    // R5 self refresh entry
    drive(0, CMD_REF,   1, 2, 1, 0, "R5 sref entry");
    drive(0, CMD_NOP,   1, 2, 0, 0, "R4 sref hold");
    drive(1, CMD_ACT,   1, 2, 0, 1, "R6 sref bad exit");
    drive(1, CMD_NOP,   1, 4, 1, 0, "R7 sref exit");
    drive(1, CMD_NOP,   1, 4, 1, 0, "R7 recov 1");
    drive(1, CMD_ACT,   1, 4, 0, 1, "R7 recov act");
    drive(1, CMD_DESL,  1, 4, 1, 0, "R7 recov 3");
    drive(1, CMD_NOP,   1, 0, 1, 0, "R7 recov done");
    drive(1, CMD_ACT,   1, 0, 1, 0, "R7 act after");
    // R5 deep power down
    drive(0, CMD_BST,   0, 0, 0, 1, "R5 dpd busy");
    drive(1, CMD_NOP,   1, 0, 1, 0, "R2 back high 2");
    drive(0, CMD_BST,   1, 3, 1, 0, "R5 dpd entry");
    drive(0, CMD_MRS,   0, 3, 0, 0, "R8 dpd ignore");
    drive(1, CMD_ACT,   0, 5, 0, 0, "R8 dpd exit");
    // R9 initialization
    drive(1, CMD_NOP,   1, 5, 1, 0, "R9 wait 1");
    drive(1, CMD_PALL,  1, 5, 0, 1, "R9 early pall");
    drive(1, CMD_NOP,   1, 5, 1, 0, "R9 wait 3");
    drive(1, CMD_ACT,   1, 5, 0, 1, "R9 act in init");
    drive(1, CMD_PALL,  1, 5, 1, 0, "R9 pall");
    drive(1, CMD_NOP,   1, 5, 1, 0, "R9 nop gap");
    drive(1, CMD_REF,   1, 5, 1, 0, "R9 ref 1");
    drive(1, CMD_EMRS,  1, 5, 0, 1, "R9 emrs early");
    drive(1, CMD_REF,   1, 5, 1, 0, "R9 ref 2");
    drive(1, CMD_MRS,   1, 5, 1, 0, "R9 mrs");
    drive(1, CMD_EMRS,  1, 0, 1, 0, "R9 emrs done");
    drive(1, CMD_ACT,   1, 0, 1, 0, "R10 act normal");
    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R10: got %0d pending results, expected 0", sb_q.size());
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule